// File: doc/BRIEF.md
# Strobe-Timed Static RAM Cycle Sequencer

This block sits between a simple host port and an asynchronous 1K x 1 static RAM that captures its address on the falling edge of its active-low chip enable. The host raises a request together with a direction flag, an address, a write bit and a burst flag, then holds them until the one-cycle completion pulse. The sequencer then produces the chip-enable, write-enable, address and data-driver waveforms. Every minimum interval is met with a whole number of clock cycles.

All timing limits are parameters in nanoseconds, along with the clock period. Each limit is rounded up to whole cycles at elaboration. Writes follow a fixed order. The address is presented ahead of the enable edge. Write enable falls together with chip enable. The data driver stays off for a turnaround window so that a shared data line cannot clash with the RAM's output. The driver then stays on long enough to meet data setup, and chip enable and write enable rise together to end the write. When a write carries the burst flag, write enable stays low across the chip-enable high gap, so a chain of writes never toggles it.

Top module: `sram_strobe_seq`

## Requirements
- R1: During and right after reset, chip enable and write enable (both active low) are high, the data driver enable is low and the completion pulse is low.
- R2: The address is driven for at least one cycle before chip enable falls, and it does not change while chip enable is low.
- R3: Chip enable stays low for at least T_ELEH_NS and high for at least T_EHEL_NS. Consecutive chip-enable falling edges are at least T_ELEL_NS apart.
- R4: Each write-enable low pulse lasts at least T_WLWH_NS, and write enable has been low for at least T_WLEH_NS when chip enable rises during a write.
- R5: The data driver is enabled only while both strobes are low, and only after write enable has been low for at least T_WLQZ_NS. It stays on for at least T_DVWH_NS before the rising edge that ends the write, and it turns off on that edge.
- R6: A read captures the RAM output no earlier than T_ELQV_NS after chip enable falls, and presents that bit on the read-data output while the completion pulse is high. Write enable is high for the whole read.
- R7: The completion output is high for exactly one clock per transfer. A request is taken only from the idle state, after the chip-enable high recovery has elapsed.
- R8: A write with the burst flag set leaves write enable low after the transfer completes. A later read raises write enable before chip enable falls, and a later write without the flag raises it together with chip enable.
- R9: A bit written to any address, including address 0 and the highest address, reads back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Transfer request, held until done_o |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_burst_i | input | 1 | Keep write enable low after this write |
| req_addr_i | input | AW | Transfer address |
| req_wdata_i | input | 1 | Bit to write |
| rd_data_o | output | 1 | Bit read, valid with done_o |
| done_o | output | 1 | One-cycle completion pulse |
| mem_e_n_o | output | 1 | RAM chip enable, active low |
| mem_w_n_o | output | 1 | RAM write enable, active low |
| mem_a_o | output | AW | RAM address |
| mem_d_o | output | 1 | RAM write data |
| mem_d_oe_o | output | 1 | Driver enable for a shared data line |
| mem_q_i | input | 1 | RAM read data |

## Verification
The timing assertions assume that the host keeps the request and its operands steady from the request until the completion pulse, and drops the request right after the pulse. The bench task drives each request after a falling clock edge and releases it on the sampling edge that sees the pulse. The read-capture checks assume that the RAM output settles within the read access time. The bench's RAM model drives the inverted stored bit until the capturing edge falls at least that long after chip enable fell, so a capture that comes too early returns a wrong bit. The model also watches for data-line contention and for writes that end without the data driver on.

// File: rtl/sram_strobe_seq.sv
module sram_strobe_seq #(
  parameter int AW         = 10,
  parameter int CLK_NS     = 4,
  parameter int T_AVEL_NS  = 0,
  parameter int T_ELAX_NS  = 40,
  parameter int T_ELEH_NS  = 180,
  parameter int T_EHEL_NS  = 100,
  parameter int T_ELEL_NS  = 280,
  parameter int T_WLWH_NS  = 100,
  parameter int T_WLEH_NS  = 100,
  parameter int T_DVWH_NS  = 80,
  parameter int T_ELQV_NS  = 180,
  parameter int T_WLQZ_NS  = 120
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_i,
  input  logic          req_we_i,
  input  logic          req_burst_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic          req_wdata_i,
  output logic          rd_data_o,
  output logic          done_o,
  output logic          mem_e_n_o,
  output logic          mem_w_n_o,
  output logic [AW-1:0] mem_a_o,
  output logic          mem_d_o,
  output logic          mem_d_oe_o,
  input  logic          mem_q_i
);

  function automatic int cyc(input int ns);
    return (ns + CLK_NS - 1) / CLK_NS;
  endfunction

  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int CW     = 16;
  localparam int C_ELAX = cyc(T_ELAX_NS);
  localparam int C_ELEH = cyc(T_ELEH_NS);
  localparam int C_EHEL = cyc(T_EHEL_NS);
  localparam int C_ELEL = cyc(T_ELEL_NS);
  localparam int C_WLWH = cyc(T_WLWH_NS);
  localparam int C_WLEH = cyc(T_WLEH_NS);
  localparam int C_DVWH = cyc(T_DVWH_NS);
  localparam int C_ELQV = cyc(T_ELQV_NS);
  localparam int C_WLQZ = cyc(T_WLQZ_NS);
  localparam int C_AS   = mx(1, cyc(T_AVEL_NS));
  localparam int C_TA   = mx(1, C_WLQZ);
  localparam int C_WACT = mx(mx(mx(1, C_DVWH), mx(C_WLWH, C_WLEH) - C_TA),
                             mx(C_ELEH, C_ELAX) - C_TA);
  localparam int C_RW   = mx(mx(C_ELQV, C_ELEH), mx(C_ELAX, 2)) - 1;
  localparam int LOW_WR = C_TA + C_WACT;
  localparam int LOW_RD = C_RW + 1;
  localparam int EH_WR  = mx(1, mx(C_EHEL, C_ELEL - LOW_WR));
  localparam int EH_RD  = mx(1, mx(C_EHEL, C_ELEL - LOW_RD));

  typedef enum logic [2:0] {
    IDLE, ADDR_SETUP, E_LOW_WAIT, W_ACTIVE, READ_SAMPLE, E_HIGH_RECOVER, DONE
  } state_t;

  state_t          state;
  logic [CW-1:0]   cnt;
  logic [AW-1:0]   addr_q;
  logic            wdata_q, op_we, op_burst, w_hold, rd_q;
  wire             cnt_zero = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= IDLE;
      cnt      <= '0;
      addr_q   <= '0;
      wdata_q  <= 1'b0;
      op_we    <= 1'b0;
      op_burst <= 1'b0;
      w_hold   <= 1'b0;
      rd_q     <= 1'b0;
    end else begin
      case (state)
        IDLE: if (req_i) begin
          addr_q   <= req_addr_i;
          wdata_q  <= req_wdata_i;
          op_we    <= req_we_i;
          op_burst <= req_burst_i;
          if (!req_we_i) w_hold <= 1'b0;
          cnt      <= CW'(C_AS - 1);
          state    <= ADDR_SETUP;
        end
        ADDR_SETUP: if (cnt_zero) begin
          cnt   <= op_we ? CW'(C_TA - 1) : CW'(C_RW - 1);
          state <= E_LOW_WAIT;
        end else cnt <= cnt - 1'b1;
        E_LOW_WAIT: if (cnt_zero) begin
          if (op_we) begin
            cnt   <= CW'(C_WACT - 1);
            state <= W_ACTIVE;
          end else state <= READ_SAMPLE;
        end else cnt <= cnt - 1'b1;
        W_ACTIVE: if (cnt_zero) begin
          w_hold <= op_burst;
          cnt    <= CW'(EH_WR - 1);
          state  <= E_HIGH_RECOVER;
        end else cnt <= cnt - 1'b1;
        READ_SAMPLE: begin
          rd_q  <= mem_q_i;
          cnt   <= CW'(EH_RD - 1);
          state <= E_HIGH_RECOVER;
        end
        E_HIGH_RECOVER: if (cnt_zero) state <= DONE;
                        else cnt <= cnt - 1'b1;
        DONE:    state <= IDLE;
        default: state <= IDLE;
      endcase
    end
  end

  assign mem_e_n_o  = !(state == E_LOW_WAIT || state == W_ACTIVE || state == READ_SAMPLE);
  assign mem_w_n_o  = !((op_we && (state == E_LOW_WAIT || state == W_ACTIVE)) || w_hold);
  assign mem_d_oe_o = (state == W_ACTIVE);
  assign mem_a_o    = addr_q;
  assign mem_d_o    = wdata_q;
  assign rd_data_o  = rd_q;
  assign done_o     = (state == DONE);

  // interval counters used only by the assertions below
  logic [CW-1:0] lo_cnt, hi_cnt, per_cnt, wlo_cnt, oe_cnt;
  logic          e_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_cnt  <= '0;
      hi_cnt  <= '1;
      per_cnt <= '1;
      wlo_cnt <= '0;
      oe_cnt  <= '0;
      e_prev  <= 1'b1;
    end else begin
      e_prev  <= mem_e_n_o;
      lo_cnt  <= mem_e_n_o ? '0 : (lo_cnt == '1 ? lo_cnt : lo_cnt + 1'b1);
      hi_cnt  <= !mem_e_n_o ? '0 : (hi_cnt == '1 ? hi_cnt : hi_cnt + 1'b1);
      per_cnt <= (!mem_e_n_o && e_prev) ? CW'(1) : (per_cnt == '1 ? per_cnt : per_cnt + 1'b1);
      wlo_cnt <= mem_w_n_o ? '0 : (wlo_cnt == '1 ? wlo_cnt : wlo_cnt + 1'b1);
      oe_cnt  <= !mem_d_oe_o ? '0 : (oe_cnt == '1 ? oe_cnt : oe_cnt + 1'b1);
    end
  end

  AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> mem_e_n_o && mem_w_n_o && !mem_d_oe_o && !done_o); // R1
  AST_ADDR_SETUP: assert property (@(posedge clk) disable iff (!rst_n) $fell(mem_e_n_o) |-> $stable(mem_a_o)); // R2
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!mem_e_n_o && $past(!mem_e_n_o)) |-> $stable(mem_a_o)); // R2
  AST_E_LOW_MIN: assert property (@(posedge clk) disable iff (!rst_n) $rose(mem_e_n_o) |-> lo_cnt >= CW'(C_ELEH)); // R3
  AST_E_HIGH_MIN: assert property (@(posedge clk) disable iff (!rst_n) $fell(mem_e_n_o) |-> hi_cnt >= CW'(C_EHEL)); // R3
  AST_E_PERIOD_MIN: assert property (@(posedge clk) disable iff (!rst_n) $fell(mem_e_n_o) |-> per_cnt >= CW'(C_ELEL)); // R3
  AST_W_WIDTH: assert property (@(posedge clk) disable iff (!rst_n) $rose(mem_w_n_o) |-> wlo_cnt >= CW'(C_WLWH)); // R4
  AST_W_BEFORE_E: assert property (@(posedge clk) disable iff (!rst_n) ($rose(mem_e_n_o) && $past(!mem_w_n_o)) |-> wlo_cnt >= CW'(C_WLEH)); // R4
  AST_OE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n) mem_d_oe_o |-> (!mem_w_n_o && !mem_e_n_o)); // R5
  AST_TURNAROUND: assert property (@(posedge clk) disable iff (!rst_n) $rose(mem_d_oe_o) |-> wlo_cnt >= CW'(C_WLQZ)); // R5
  AST_DATA_SETUP: assert property (@(posedge clk) disable iff (!rst_n) ($rose(mem_e_n_o) && $past(!mem_w_n_o)) |-> oe_cnt >= CW'(C_DVWH)); // R5
  AST_READ_W_HIGH: assert property (@(posedge clk) disable iff (!rst_n) (state == READ_SAMPLE) |-> (mem_w_n_o && lo_cnt >= CW'(C_ELQV - 1))); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done_o |=> !done_o); // R7
  AST_BURST_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (done_o && op_we && op_burst) |-> !mem_w_n_o); // R8

endmodule

// File: tb/sram_strobe_seq_tb_top.sv
module sram_strobe_seq_tb_top;
  localparam int AW = 10;
  localparam int CLK_NS = 4;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, req_we = 1'b0, req_burst = 1'b0, req_wdata = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic rd_data, done, e_n, w_n, d_o, d_oe, q;
  logic [AW-1:0] a;

  always #2 clk = ~clk;

  sram_strobe_seq #(.AW(AW), .CLK_NS(CLK_NS)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_i(req), .req_we_i(req_we), .req_burst_i(req_burst),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .rd_data_o(rd_data), .done_o(done),
    .mem_e_n_o(e_n), .mem_w_n_o(w_n), .mem_a_o(a), .mem_d_o(d_o), .mem_d_oe_o(d_oe),
    .mem_q_i(q)
  );

  int n_chk = 0, n_fail = 0;
  int ops = 0, dones = 0;
  bit op_is_read = 1'b0;

  task automatic check(input bit ok, input string req_tag, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req_tag, what, act, exp);
    end
  endtask

  // RAM model and interval monitor
  logic mem [0:DEPTH-1];
  logic [AW-1:0] lat_a = '0;
  logic pe = 1'b1, pw = 1'b1, poe = 1'b0, pd = 1'b0;
  logic [AW-1:0] pa = '0;
  int low_run = 0, high_run = 0, per_run = 0, wlo_run = 0, oe_run = 0;
  bit seen_fall = 1'b0;
  int min_elow = 1000000, min_ehigh = 1000000, min_per = 1000000;
  int min_wlow = 1000000, min_ta = 1000000, min_setup = 1000000;
  int bad_write = 0, clash = 0, addr_bad = 0, read_w_low = 0;

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = 1'b0;
    q = 1'b0;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (done) dones++;
      if (pe && !e_n) begin
        lat_a = a;
        if (a != pa) addr_bad++;
        if (!w_n && op_is_read) read_w_low++;
        if (seen_fall) begin
          if (high_run < min_ehigh) min_ehigh = high_run;
          if (per_run < min_per) min_per = per_run;
        end
        seen_fall = 1'b1;
        per_run = 0;
        low_run = 0;
      end
      if (!pe && !e_n && a != pa) addr_bad++;
      if (!pe && e_n) begin
        if (low_run < min_elow) min_elow = low_run;
        high_run = 0;
      end
      if (!pe && !pw && (e_n || w_n)) begin
        if (poe) mem[lat_a] = pd; else bad_write++;
        if (oe_run < min_setup) min_setup = oe_run;
      end
      if (!pw && w_n && wlo_run < min_wlow) min_wlow = wlo_run;
      if (!poe && d_oe && wlo_run < min_ta) min_ta = wlo_run;
      if (!e_n) low_run++; else high_run++;
      per_run++;
      if (!w_n) wlo_run++; else wlo_run = 0;
      if (d_oe) oe_run++; else oe_run = 0;
      if (!e_n && w_n) begin
        q = (low_run * CLK_NS >= 180) ? mem[lat_a] : ~mem[lat_a];
        if (d_oe) clash++;
      end else q = ~q;
      pe = e_n; pw = w_n; poe = d_oe; pd = d_o; pa = a;
    end
  end

  bit hung = 1'b0;

  task automatic do_op(input bit we, input bit burst, input logic [AW-1:0] ad, input bit wd, output bit rd);
    int waited;
    @(negedge clk);
    op_is_read = !we;
    req = 1'b1; req_we = we; req_burst = burst; req_addr = ad; req_wdata = wd;
    waited = 0;
    while (!done && waited < 2000) begin
      @(negedge clk);
      waited++;
    end
    if (!done) hung = 1'b1;
    check(done, "R7", "transfer completes", int'(done), 1);
    rd = rd_data;
    req = 1'b0;
    ops++;
    @(negedge clk);
    check(!done, "R7", "done one cycle", int'(done), 0);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    check(e_n == 1'b1, "R1", "E in reset", int'(e_n), 1);
    check(w_n == 1'b1, "R1", "W in reset", int'(w_n), 1);
    check(d_oe == 1'b0, "R1", "driver in reset", int'(d_oe), 0);
    check(done == 1'b0, "R1", "done in reset", int'(done), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(e_n && w_n && !d_oe, "R1", "idle after reset", int'({e_n, w_n, d_oe}), 6);
  endtask

  task automatic t_write_read;
    bit r;
    for (int i = 0; i < 12; i++) do_op(1'b1, 1'b0, AW'(i * 37 + 5), 1'(i ^ (i >> 1)), r);
    for (int i = 0; i < 12; i++) begin
      do_op(1'b0, 1'b0, AW'(i * 37 + 5), 1'b0, r);
      check(r == 1'(i ^ (i >> 1)), "R9", "readback pattern", int'(r), int'(1'(i ^ (i >> 1))));
    end
    do_op(1'b1, 1'b0, AW'(5), 1'b1, r);
    do_op(1'b0, 1'b0, AW'(5), 1'b0, r);
    check(r == 1'b1, "R6", "read captured after access time", int'(r), 1);
  endtask

  task automatic t_boundaries;
    bit r;
    do_op(1'b1, 1'b0, '0, 1'b1, r);
    do_op(1'b1, 1'b0, '1, 1'b1, r);
    do_op(1'b1, 1'b0, AW'(1), 1'b0, r);
    do_op(1'b0, 1'b0, '0, 1'b0, r);
    check(r == 1'b1, "R9", "address 0", int'(r), 1);
    do_op(1'b0, 1'b0, '1, 1'b0, r);
    check(r == 1'b1, "R9", "top address", int'(r), 1);
    do_op(1'b1, 1'b0, '1, 1'b0, r);
    do_op(1'b0, 1'b0, '1, 1'b1, r);
    check(r == 1'b0, "R9", "top address overwrite", int'(r), 0);
  endtask

  task automatic t_burst;
    bit r;
    do_op(1'b1, 1'b1, AW'(100), 1'b1, r);
    check(w_n == 1'b0, "R8", "W held low after burst write", int'(w_n), 0);
    do_op(1'b1, 1'b1, AW'(101), 1'b0, r);
    check(w_n == 1'b0, "R8", "W still low in chain", int'(w_n), 0);
    do_op(1'b1, 1'b0, AW'(102), 1'b1, r);
    check(w_n == 1'b1, "R8", "W released after last write", int'(w_n), 1);
    do_op(1'b1, 1'b1, AW'(103), 1'b1, r);
    do_op(1'b0, 1'b0, AW'(100), 1'b0, r);
    check(r == 1'b1, "R8", "read after burst, addr 100", int'(r), 1);
    do_op(1'b0, 1'b0, AW'(101), 1'b0, r);
    check(r == 1'b0, "R8", "burst addr 101", int'(r), 0);
    do_op(1'b0, 1'b0, AW'(102), 1'b0, r);
    check(r == 1'b1, "R8", "burst addr 102", int'(r), 1);
    do_op(1'b0, 1'b0, AW'(103), 1'b0, r);
    check(r == 1'b1, "R8", "burst addr 103", int'(r), 1);
  endtask

  task automatic t_timing;
    check(addr_bad == 0, "R2", "address setup/hold violations", addr_bad, 0);
    check(min_elow * CLK_NS >= 180, "R3", "E low ns", min_elow * CLK_NS, 180);
    check(min_ehigh * CLK_NS >= 100, "R3", "E high ns", min_ehigh * CLK_NS, 100);
    check(min_per * CLK_NS >= 280, "R3", "E period ns", min_per * CLK_NS, 280);
    check(min_wlow * CLK_NS >= 100, "R4", "W low ns", min_wlow * CLK_NS, 100);
    check(min_ta * CLK_NS >= 120, "R5", "turnaround ns", min_ta * CLK_NS, 120);
    check(min_setup * CLK_NS >= 80, "R5", "data setup ns", min_setup * CLK_NS, 80);
    check(bad_write == 0, "R5", "writes without driver", bad_write, 0);
    check(clash == 0, "R5", "bus contention", clash, 0);
    check(read_w_low == 0, "R6", "read started with W low", read_w_low, 0);
    check(dones == ops, "R7", "done pulses per transfer", dones, ops);
  endtask

  bit finished = 1'b0;

  task automatic summary;
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    t_reset;
    t_write_read;
    t_boundaries;
    t_burst;
    t_timing;
    check(!hung, "R7", "no hung transfer", int'(hung), 0);
    summary;
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "R7", "watchdog expired", 1, 0);
    summary;
  end
endmodule